// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This engine sits inside a one-wire bus master and speeds up the ROM search. Outside logic first issues the bus reset and the search command byte. It then turns the accelerator mode on. From that point, every byte the host hands over makes the engine settle four consecutive identifier positions.

For each position the engine asks a slot generator for two read slots. The first returns the identifier bit and the second returns its complement. The engine then picks a branch direction and asks for one write slot that carries the chosen bit. When all four positions are done, it offers a reply byte. The reply places each chosen bit next to a flag that marks a conflict, or an empty bus, at that position.

A full 64-bit identifier takes sixteen byte exchanges. Exchange number i covers identifier bits 4i to 4i+3, so software builds the identifier one nibble at a time, starting with the low nibble. Turning the mode off abandons any byte in progress. Outside logic then resets the bus.

Top module: `ow_search_accel`

## Requirements
- R1: After reset, `rx_full` is 0, `rx_byte` is 0x00 and `slot_req` is 0.
- R2: A pulse on `host_wr` starts a byte only when `acc_en` is 1. With `acc_en` at 0 the pulse issues no slot and never sets `rx_full`.
- R3: Each byte runs exactly 12 slots. For each position, in order, there is a read slot for the true bit, then a read slot for the complement, then one write slot (`slot_op` 0 = read, 1 = write). The first slot of a byte is always a read.
- R4: When the true and complement reads differ, the chosen bit equals the true read and the flag is 0.
- R5: When both reads are 0, the flag is 1 and the chosen bit for position p is bit 2p+1 of the byte the host wrote.
- R6: When both reads are 1, the flag is 1 and the chosen bit is 1.
- R7: The write slot of each position carries the chosen bit on `slot_wbit`, and the bit holds steady while the slot is pending.
- R8: In `rx_byte`, bit 2p+1 holds the chosen bit of position p and bit 2p holds its flag. Position 0 is the first one resolved on the bus.
- R9: `rx_full` rises only in the cycle after the fourth write slot completes. A pulse on `host_rd` clears it. `rx_byte` changes only when a byte completes.
- R10: Clearing `acc_en` during a byte stops the engine. No further slot is requested, and `rx_full` is not set for that byte.
- R11: A `host_wr` pulse that arrives while a byte is still in progress is ignored. Neither the slot count nor the reply changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Accelerator mode enable |
| host_wr | input | 1 | One-cycle pulse: host delivers a byte |
| host_wdata | input | 8 | Host byte; odd bits give directions for double-zero positions |
| host_rd | input | 1 | One-cycle pulse: host has taken the reply |
| rx_byte | output | 8 | Reply byte: chosen bits at odd positions, flags at even positions |
| rx_full | output | 1 | A reply is waiting |
| slot_req | output | 1 | Slot request, held until `slot_done` |
| slot_op | output | 1 | 0 = read slot, 1 = write slot |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle pulse: the requested slot has finished |
| slot_rbit | input | 1 | Bus sample of a read slot, valid with `slot_done` |

## Verification
The assertions assume that `slot_done` pulses for exactly one cycle, and only while `slot_req` is high. They also assume that `slot_rbit` is meaningful only with that pulse. The bench's slot model keeps to this. It raises `slot_done` for a single cycle after a fixed delay, only when it sees a pending request, and drops it before it looks again. The assertions further assume that `host_rd` and `host_wr` are single-cycle pulses, and the bench drives both only as one-cycle strobes on the falling edge.

// File: rtl/ow_sra_pkg.sv
// Shared types for the one-wire search accelerator.
// Assumes a single clock domain with synchronous active-low reset.
package ow_sra_pkg;

    typedef enum logic [1:0] {
        SRA_IDLE    = 2'd0,
        SRA_RD_TRUE = 2'd1,
        SRA_RD_CMP  = 2'd2,
        SRA_WRITE   = 2'd3
    } sra_state_t;

endpackage

// File: rtl/ow_sra_pick.sv
// Direction selector for one search position.
// Takes the true read, the complement read and the host hint.
// Returns the chosen branch bit and the conflict/empty flag.
// Purely combinational; its inputs are assumed stable during the write slot.
module ow_sra_pick (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic hint_bit,
    output logic dir_bit,
    output logic flag_bit
);

    // Choose the branch from the two reads, falling back on the hint.
    always_comb begin
        if (id_bit != cmp_bit) begin
            dir_bit  = id_bit;
            flag_bit = 1'b0;
        end else if (!id_bit) begin
            dir_bit  = hint_bit;
            flag_bit = 1'b1;
        end else begin
            dir_bit  = 1'b1;
            flag_bit = 1'b1;
        end
    end

endmodule

// File: rtl/ow_sra_seq.sv
// Slot sequencer: runs read-true, read-complement, write for each of
// NPOS positions and signals each finished position and the finished byte.
// Assumes slot_done pulses for one cycle while slot_req is high.
module ow_sra_seq
    import ow_sra_pkg::*;
#(
    parameter int NPOS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    host_wr,
    input  logic [2*NPOS-1:0]       host_wdata,
    input  logic                    slot_done,
    input  logic                    slot_rbit,
    output logic                    slot_req,
    output logic                    slot_op,
    output logic [$clog2(NPOS)-1:0] pos,
    output logic [2*NPOS-1:0]       host_q,
    output logic                    id_q,
    output logic                    cmp_q,
    output logic                    step_done,
    output logic                    byte_done
);

    localparam int POS_W = $clog2(NPOS);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NPOS - 1);

    sra_state_t state;
    logic       start;

    assign start     = host_wr && acc_en && (state == SRA_IDLE);
    assign slot_req  = (state != SRA_IDLE);
    assign slot_op   = (state == SRA_WRITE);
    assign step_done = (state == SRA_WRITE) && slot_done;
    assign byte_done = step_done && (pos == LAST_POS);

    // State, position counter and captured reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SRA_IDLE;
            pos    <= '0;
            host_q <= '0;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
        end else if (!acc_en) begin
            state <= SRA_IDLE;
            pos   <= '0;
        end else begin
            case (state)
                SRA_IDLE: if (start) begin
                    host_q <= host_wdata;
                    pos    <= '0;
                    state  <= SRA_RD_TRUE;
                end
                SRA_RD_TRUE: if (slot_done) begin
                    id_q  <= slot_rbit;
                    state <= SRA_RD_CMP;
                end
                SRA_RD_CMP: if (slot_done) begin
                    cmp_q <= slot_rbit;
                    state <= SRA_WRITE;
                end
                SRA_WRITE: if (slot_done) begin
                    if (pos == LAST_POS) begin
                        pos   <= '0;
                        state <= SRA_IDLE;
                    end else begin
                        pos   <= pos + 1'b1;
                        state <= SRA_RD_TRUE;
                    end
                end
                default: state <= SRA_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ow_sra_pack.sv
// Reply packer: stores {dir, flag} of each position at pair pos.
// Publishes the byte and raises the full flag when the byte finishes.
// Assumes step_done and byte_done come from the sequencer; byte_done implies step_done.
module ow_sra_pack #(
    parameter int NPOS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_done,
    input  logic                    byte_done,
    input  logic [$clog2(NPOS)-1:0] pos,
    input  logic                    dir_bit,
    input  logic                    flag_bit,
    input  logic                    host_rd,
    output logic [2*NPOS-1:0]       rx_byte,
    output logic                    rx_full
);

    localparam int BYTE_W = 2 * NPOS;

    logic [BYTE_W-1:0] work_q;
    logic [BYTE_W-1:0] work_next;

    // Merge the current position into the working reply.
    always_comb begin
        work_next = work_q;
        work_next[2*int'(pos) +: 2] = {dir_bit, flag_bit};
    end

    // Working reply, published reply and full flag (a set wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            rx_byte <= '0;
            rx_full <= 1'b0;
        end else begin
            if (step_done) work_q <= work_next;
            if (byte_done) begin
                rx_byte <= work_next;
                rx_full <= 1'b1;
            end else if (host_rd) begin
                rx_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ow_search_accel.sv
// Top of the one-wire ROM search accelerator.
// Each accepted host byte resolves NPOS search positions through the slot
// generator and returns an interleaved reply of chosen bits and flags.
// Assumes bus reset and the search command are issued elsewhere.
module ow_search_accel #(
    parameter int NPOS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                host_wr,
    input  logic [2*NPOS-1:0]   host_wdata,
    input  logic                host_rd,
    output logic [2*NPOS-1:0]   rx_byte,
    output logic                rx_full,
    output logic                slot_req,
    output logic                slot_op,
    output logic                slot_wbit,
    input  logic                slot_done,
    input  logic                slot_rbit
);

    localparam int POS_W  = $clog2(NPOS);
    localparam int BYTE_W = 2 * NPOS;

    logic [POS_W-1:0]  pos;
    logic [BYTE_W-1:0] host_q;
    logic [NPOS-1:0]   hints;
    logic              id_q, cmp_q, step_done, byte_done, flag_bit;

    // Hints for double-zero positions sit in the odd bits of the host byte.
    for (genvar p = 0; p < NPOS; p++) begin : g_hint
        assign hints[p] = host_q[2*p+1];
    end

    ow_sra_seq #(.NPOS(NPOS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .slot_done  (slot_done),
        .slot_rbit  (slot_rbit),
        .slot_req   (slot_req),
        .slot_op    (slot_op),
        .pos        (pos),
        .host_q     (host_q),
        .id_q       (id_q),
        .cmp_q      (cmp_q),
        .step_done  (step_done),
        .byte_done  (byte_done)
    );

    ow_sra_pick u_pick (
        .id_bit   (id_q),
        .cmp_bit  (cmp_q),
        .hint_bit (hints[pos]),
        .dir_bit  (slot_wbit),
        .flag_bit (flag_bit)
    );

    ow_sra_pack #(.NPOS(NPOS)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_done (step_done),
        .byte_done (byte_done),
        .pos       (pos),
        .dir_bit   (slot_wbit),
        .flag_bit  (flag_bit),
        .host_rd   (host_rd),
        .rx_byte   (rx_byte),
        .rx_full   (rx_full)
    );

endmodule

// File: rtl/ow_search_accel_chk.sv
// Port-level checker for the search accelerator, bound to the top.
// Assumes slot_done is a single-cycle pulse given only while slot_req is high.
module ow_search_accel_chk #(
    parameter int NPOS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              host_rd,
    input logic [2*NPOS-1:0] rx_byte,
    input logic              rx_full,
    input logic              slot_req,
    input logic              slot_op,
    input logic              slot_wbit,
    input logic              slot_done
);

    // R10: with the mode off, no slot is requested on the next cycle.
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !slot_req);

    // R9: the full flag rises only right after a completed write slot.
    a_r9_full_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(slot_done && slot_op));

    // R9: a read with no completing slot clears the full flag.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !(slot_done && slot_op)) |=> !rx_full);

    // R9: the reply changes only after a slot completes.
    a_r9_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slot_done) |-> $stable(rx_byte));

    // R7: a pending write slot keeps its data bit.
    a_r7_wbit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && slot_op && !slot_done && acc_en) |=> $stable(slot_wbit));

    // R3: a byte always opens with a read slot.
    a_r3_first_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_req) |-> !slot_op);

endmodule

bind ow_search_accel ow_search_accel_chk #(.NPOS(NPOS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .host_rd   (host_rd),
    .rx_byte   (rx_byte),
    .rx_full   (rx_full),
    .slot_req  (slot_req),
    .slot_op   (slot_op),
    .slot_wbit (slot_wbit),
    .slot_done (slot_done)
);

// File: tb/ow_search_accel_test.sv
module ow_search_accel_test;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT_DLY   = 3;
    localparam int NVEC       = 6;

    // {host byte, read pattern (pos p: bit 2p true, 2p+1 complement), reply, written nibble}
    localparam logic [27:0] VEC [NVEC] = '{
        {8'h00, 8'h99, 8'h22, 4'h5},
        {8'hAA, 8'h00, 8'hFF, 4'hF},
        {8'h00, 8'h00, 8'h55, 4'h0},
        {8'h00, 8'hFF, 8'hFF, 4'hF},
        {8'h08, 8'h63, 8'h8F, 4'hB},
        {8'h80, 8'h00, 8'hD5, 4'h8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_full;
    logic       slot_req, slot_op, slot_wbit;
    logic       slot_done = 1'b0;
    logic       slot_rbit = 1'b0;

    int   n_checks = 0;
    int   n_fail = 0;
    logic [7:0]  rd_pat = 8'h00;
    int          rd_idx = 0;
    int          wr_idx = 0;
    int          slot_cnt = 0;
    logic [3:0]  wr_nib = 4'h0;
    logic [11:0] op_log = 12'h000;
    int          dly = 0;
    bit          done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ow_search_accel uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .rx_byte(rx_byte),
        .rx_full(rx_full), .slot_req(slot_req), .slot_op(slot_op),
        .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    // Slot generator model: completes each request after SLOT_DLY cycles.
    always @(negedge clk) begin
        if (slot_done) begin
            slot_done = 1'b0;
            dly = 0;
        end else if (slot_req) begin
            if (dly == SLOT_DLY) begin
                if (slot_cnt < 12) op_log[slot_cnt] = slot_op;
                slot_cnt++;
                if (slot_op) begin
                    if (wr_idx < 4) wr_nib[wr_idx] = slot_wbit;
                    wr_idx++;
                end else begin
                    slot_rbit = (rd_idx < 8) ? rd_pat[rd_idx] : 1'b0;
                    rd_idx++;
                end
                slot_done = 1'b1;
            end else begin
                dly++;
            end
        end else begin
            dly = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_log(input logic [7:0] pat);
        rd_pat = pat; rd_idx = 0; wr_idx = 0; slot_cnt = 0;
        wr_nib = 4'h0; op_log = 12'h000;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); host_wdata = b; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic wait_full(output bit ok);
        ok = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rx_full) begin ok = 1; break; end
        end
    endtask

    task automatic read_reply;
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_full", rx_full, 0);
        check("R1 rx_byte", rx_byte, 0);
        check("R1 slot_req", slot_req, 0);

        // R2: a write with the mode off does nothing
        clear_log(8'h00);
        send(8'h00);
        repeat (20) @(negedge clk);
        check("R2 slots with mode off", slot_cnt, 0);
        check("R2 rx_full with mode off", rx_full, 0);

        acc_en = 1'b1;
        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            clear_log(VEC[v][19:12]);
            send(VEC[v][27:20]);
            wait_full(ok);
            check("R9 reply arrives", ok, 1);
            check("R9 full only after four writes", wr_idx, 4);
            check("R3 slot count", slot_cnt, 12);
            check("R3 slot order", op_log, 12'h924);
            check("R4 R5 R6 R8 reply byte", rx_byte, VEC[v][11:4]);
            check("R7 written bits", wr_nib, VEC[v][3:0]);
            read_reply();
            @(negedge clk);
            check("R9 host_rd clears full", rx_full, 0);
            check("R9 reply held after read", rx_byte, VEC[v][11:4]);
        end

        // R11: a second write during a running byte is ignored
        clear_log(8'h00);
        send(8'h00);
        repeat (3) @(negedge clk);
        send(8'hAA);
        wait_full(ok);
        repeat (40) @(negedge clk);
        check("R11 slot count", slot_cnt, 12);
        check("R11 reply uses first byte", rx_byte, 8'h55);
        read_reply();

        // R10: dropping the mode mid-byte abandons the byte
        clear_log(8'hFF);
        send(8'h00);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (slot_cnt >= 2) break;
        end
        acc_en = 1'b0;
        repeat (2) @(negedge clk);
        begin
            int snap;
            snap = slot_cnt;
            repeat (30) @(negedge clk);
            check("R10 no more slots", slot_cnt, snap);
        end
        check("R10 slot_req low", slot_req, 0);
        check("R10 rx_full stays low", rx_full, 0);
        check("R10 reply unchanged", rx_byte, 8'h55);

        // R9 recovery: a fresh byte runs fully after re-entry
        acc_en = 1'b1;
        clear_log(8'h99);
        send(8'h00);
        wait_full(ok);
        check("R9 reply after re-entry", rx_byte, 8'h22);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule